// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This unit executes the data-movement half of a decoded load or store. Each instruction gives an opcode class, a mode tag, a data register index, a base register index and an operand field A. The unit works out where the operand is according to the mode tag. It then makes the memory trips the mode needs, zero, one or two, on a single-port memory with a request/ready handshake. It finishes with a one-cycle done pulse that reports the operand, the number of data-memory accesses used and whether the instruction was illegal.

Loads place the fetched value in an internal eight-entry register file. Stores take the value from that file. Both classes use the same effective-address arithmetic. The current program counter is an input and is sampled when an instruction is accepted. Instructions are accepted only while the unit is idle.

Top module: `opfetch_unit`

## Requirements
- R1: After reset, `busy`, `done`, `illegal` and `mem_req` are 0, and every register reads as 0.
- R2: Mode 0 (immediate) load: the operand is A, `acc_count` is 0 at done, no memory request is made, and A is written to R[data].
- R3: Mode 1 (register) load: the operand is R[base], `acc_count` is 0, and no memory request is made.
- R4: Mode 2 (direct): exactly one access, at address A.
- R5: Mode 3 (register-indirect): exactly one access, at address R[base].
- R6: Mode 4 (memory-indirect): a read at A comes first. Its data becomes the address of a second access. `acc_count` is 2.
- R7: Mode 5 (indexed): one access, at A + R[base] modulo 2^16.
- R8: Mode 6 (PC-relative): one access, at pc + A modulo 2^16, with pc taken in the accept cycle.
- R9: When `op_store`=1, the address sequence is the same as for a load. The last access has `mem_we`=1 and `mem_wdata`=R[data], any earlier access is a read, and no register changes.
- R10: A store with mode 0 or 1, or any instruction with mode 7, gives `illegal`=1 with done and `acc_count`=0. It makes no access and writes no register.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold.
- R12: `done` lasts one cycle and only occurs while `busy`. A `start` while busy is ignored.
- R13: A loaded value is in R[data] for the next instruction accepted after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept an instruction when idle |
| op_store | input | 1 | 1 = store, 0 = load |
| mode | input | 3 | Addressing-mode tag (0..7) |
| data_idx | input | 3 | Load destination / store source register |
| base_idx | input | 3 | Register used by register, indirect and indexed modes |
| opnd_a | input | 16 | Operand field A |
| pc | input | 16 | Current program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 16 | Read data, valid with ready |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Instruction rejected, valid with done |
| operand | output | 16 | Value loaded or stored, valid with done |
| acc_count | output | 2 | Data-memory accesses used, valid with done |

## Verification
The hardest case to reach is a memory-indirect store. It needs the pointer read to return data that steers the second trip, and that second trip must become a write while the first stays a read. The bench first builds the register file through immediate loads. It then seeds a bench-side memory with a pointer word and runs the store with several ready delays. The bench records every handshake in order and checks the pointer read, the write address taken from it, and the write data. Stray starts during long waits show whether an accepted instruction can be disturbed.

// File: rtl/opf_pkg.sv
// Shared types and helpers for the operand fetch unit.
// Assumes a three-bit mode tag; code 7 is reserved and rejected.
package opf_pkg;

    typedef enum logic [2:0] {
        AM_IMM   = 3'd0,
        AM_REG   = 3'd1,
        AM_DIR   = 3'd2,
        AM_RIND  = 3'd3,
        AM_MIND  = 3'd4,
        AM_IDX   = 3'd5,
        AM_PCREL = 3'd6,
        AM_RSVD  = 3'd7
    } amode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PTR   = 2'd1,
        ST_FINAL = 2'd2,
        ST_DONE  = 2'd3
    } fstate_t;

    localparam int unsigned ACC_W = 2;

    // Operand already inside the unit: no trip to memory.
    function automatic logic mode_no_mem(amode_t m);
        return (m == AM_IMM) || (m == AM_REG);
    endfunction

    // Rejected combinations.
    function automatic logic mode_bad(amode_t m, logic is_store);
        return (m == AM_RSVD) || (is_store && mode_no_mem(m));
    endfunction

endpackage

// File: rtl/opf_regfile.sv
// Register file: NREG entries of W bits, two combinational read ports,
// one synchronous write port. Assumes NREG is a power of two.
module opf_regfile #(
    parameter int unsigned W    = 16,
    parameter int unsigned NREG = 8,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);

    logic [W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        // Per-entry storage with clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_addr == IW'(g)))
                regs[g] <= wr_data;
        end
    end

    // Read ports.
    always_comb begin
        ra_data = regs[ra_addr];
        rb_data = regs[rb_addr];
    end

endmodule

// File: rtl/opf_ea_calc.sv
// Effective-address arithmetic for every mode that reaches memory.
// All sums wrap modulo 2^W. The memory-indirect result is the pointer
// fetched earlier; for non-memory modes the output is unused.
module opf_ea_calc
    import opf_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  amode_t       mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] ptr,
    output logic [W-1:0] ea
);

    // Mode-selected address; one adder shared by indexed and PC-relative.
    logic [W-1:0] addend;

    always_comb begin
        addend = (mode == AM_PCREL) ? pc : base_val;
        unique case (mode)
            AM_DIR:            ea = a;
            AM_RIND:           ea = base_val;
            AM_MIND:           ea = ptr;
            AM_IDX, AM_PCREL:  ea = a + addend;
            default:           ea = a;
        endcase
    end

endmodule

// File: rtl/opf_seq.sv
// Sequencer: accepts an instruction when idle, runs up to two memory
// trips holding each request until ready, then pulses done for one cycle.
// Assumes read data is valid in the cycle ready is high.
module opf_seq
    import opf_pkg::*;
#(
    parameter int unsigned W   = 16,
    parameter int unsigned NREG = 8,
    localparam int unsigned IW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_store,
    input  logic [2:0]       mode,
    input  logic [IW-1:0]    data_idx,
    input  logic [IW-1:0]    base_idx,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     pc,
    input  logic [W-1:0]     base_val,
    input  logic [W-1:0]     data_val,
    input  logic [W-1:0]     ea,
    output logic [IW-1:0]    base_addr,
    output logic [IW-1:0]    data_addr,
    output logic             wr_en,
    output amode_t           mode_q,
    output logic [W-1:0]     a_q,
    output logic [W-1:0]     pc_q,
    output logic [W-1:0]     ptr_q,
    output logic [W-1:0]     res_q,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic             mem_ready,
    input  logic [W-1:0]     mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic [ACC_W-1:0] acc_count
);

    fstate_t          st_q;
    logic             store_q;
    logic             ill_q;
    logic [IW-1:0]    d_q;
    logic [IW-1:0]    b_q;
    logic [ACC_W-1:0] cnt_q;
    amode_t           mode_in;
    logic             bad_in;

    // Decode of the incoming tag.
    always_comb begin
        mode_in = amode_t'(mode);
        bad_in  = mode_bad(mode_in, op_store);
    end

    // State, latched fields, pointer, result and access count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            store_q <= 1'b0;
            ill_q   <= 1'b0;
            d_q     <= '0;
            b_q     <= '0;
            mode_q  <= AM_IMM;
            a_q     <= '0;
            pc_q    <= '0;
            ptr_q   <= '0;
            res_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start) begin
                    store_q <= op_store;
                    ill_q   <= bad_in;
                    d_q     <= data_idx;
                    b_q     <= base_idx;
                    mode_q  <= mode_in;
                    a_q     <= opnd_a;
                    pc_q    <= pc;
                    cnt_q   <= '0;
                    res_q   <= (mode_in == AM_REG) ? base_val : opnd_a;
                    if (bad_in || mode_no_mem(mode_in))
                        st_q <= ST_DONE;
                    else if (mode_in == AM_MIND)
                        st_q <= ST_PTR;
                    else
                        st_q <= ST_FINAL;
                end
                ST_PTR: if (mem_ready) begin
                    ptr_q <= mem_rdata;
                    cnt_q <= cnt_q + 1'b1;
                    st_q  <= ST_FINAL;
                end
                ST_FINAL: if (mem_ready) begin
                    res_q <= store_q ? data_val : mem_rdata;
                    cnt_q <= cnt_q + 1'b1;
                    st_q  <= ST_DONE;
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Register-file addressing and load write-back at done.
    always_comb begin
        base_addr = (st_q == ST_IDLE) ? base_idx : b_q;
        data_addr = d_q;
        wr_en     = (st_q == ST_DONE) && !store_q && !ill_q;
    end

    // Memory port and completion outputs.
    always_comb begin
        mem_req   = (st_q == ST_PTR) || (st_q == ST_FINAL);
        mem_we    = (st_q == ST_FINAL) && store_q;
        mem_addr  = (st_q == ST_PTR) ? a_q : ea;
        mem_wdata = mem_we ? data_val : '0;
        busy      = (st_q != ST_IDLE);
        done      = (st_q == ST_DONE);
        illegal   = done && ill_q;
        acc_count = cnt_q;
    end

endmodule

// File: rtl/opfetch_unit.sv
// Top of the operand fetch unit: register file, address arithmetic and
// sequencer. Loads write R[data_idx] in the done cycle; stores read it.
module opfetch_unit
    import opf_pkg::*;
#(
    parameter int unsigned W    = 16,
    parameter int unsigned NREG = 8,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_store,
    input  logic [2:0]       mode,
    input  logic [IW-1:0]    data_idx,
    input  logic [IW-1:0]    base_idx,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     pc,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic             mem_ready,
    input  logic [W-1:0]     mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic [W-1:0]     operand,
    output logic [ACC_W-1:0] acc_count
);

    logic [IW-1:0] base_addr, data_addr;
    logic [W-1:0]  base_val, data_val, ea;
    logic          wr_en;
    amode_t        mode_q;
    logic [W-1:0]  a_q, pc_q, ptr_q, res_q;

    opf_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (base_addr),
        .ra_data (base_val),
        .rb_addr (data_addr),
        .rb_data (data_val),
        .wr_en   (wr_en),
        .wr_addr (data_addr),
        .wr_data (res_q)
    );

    opf_ea_calc #(.W(W)) u_ea (
        .mode     (mode_q),
        .a        (a_q),
        .base_val (base_val),
        .pc       (pc_q),
        .ptr      (ptr_q),
        .ea       (ea)
    );

    opf_seq #(.W(W), .NREG(NREG)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_store  (op_store),
        .mode      (mode),
        .data_idx  (data_idx),
        .base_idx  (base_idx),
        .opnd_a    (opnd_a),
        .pc        (pc),
        .base_val  (base_val),
        .data_val  (data_val),
        .ea        (ea),
        .base_addr (base_addr),
        .data_addr (data_addr),
        .wr_en     (wr_en),
        .mode_q    (mode_q),
        .a_q       (a_q),
        .pc_q      (pc_q),
        .ptr_q     (ptr_q),
        .res_q     (res_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal),
        .acc_count (acc_count)
    );

    // Operand reported with done.
    always_comb operand = res_q;

endmodule

// File: rtl/opf_checker.sv
// Port-level temporal checks for opfetch_unit, attached by bind.
module opf_checker #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         done,
    input logic         illegal,
    input logic [1:0]   acc_count,
    input logic         mem_req,
    input logic         mem_ready,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] mem_wdata
);

    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_illegal_noacc: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && acc_count == 2'd0);

    a_r1_idle_noreq: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> acc_count != 2'd3);

    a_r12_done_noreq: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

endmodule

bind opfetch_unit opf_checker #(.W(W)) u_opf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .acc_count (acc_count),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/tb_opfetch_unit.sv
module tb_opfetch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_store = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [2:0]  data_idx = 3'd0;
    logic [2:0]  base_idx = 3'd0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] pc = 16'd0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = 16'd0;
    logic        busy, done, illegal;
    logic [15:0] operand;
    logic [1:0]  acc_count;

    int total = 0;
    int bad = 0;

    logic [15:0] mem [256];
    int          lat = 0;
    int          nlog = 0;
    logic [15:0] log_addr [4];
    logic        log_we [4];
    logic [15:0] log_wd [4];
    logic [15:0] got_op;
    logic [1:0]  got_cnt;
    logic        got_ill;

    opfetch_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
        .mode(mode), .data_idx(data_idx), .base_idx(base_idx),
        .opnd_a(opnd_a), .pc(pc), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .illegal(illegal),
        .operand(operand), .acc_count(acc_count)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder with a programmable ready delay; logs every access.
    initial begin
        int waitc = 0;
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (rst_n && mem_req) begin
                if (waitc >= lat) begin
                    waitc = 0;
                    mem_ready = 1'b1;
                    mem_rdata = mem[mem_addr[7:0]];
                    if (nlog < 4) begin
                        log_addr[nlog] = mem_addr;
                        log_we[nlog]   = mem_we;
                        log_wd[nlog]   = mem_wdata;
                    end
                    nlog++;
                    if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
                end else begin
                    waitc++;
                end
            end else begin
                waitc = 0;
            end
        end
    end

    // Issue one instruction and wait for done; optional stray start while busy.
    task automatic issue(input logic st, input logic [2:0] m, input logic [2:0] d,
                         input logic [2:0] b, input logic [15:0] a,
                         input logic [15:0] pcv, input int l, input bit poke);
        int n = 0;
        lat  = l;
        nlog = 0;
        @(negedge clk);
        op_store = st; mode = m; data_idx = d; base_idx = b;
        opnd_a = a; pc = pcv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke && !done) begin
            op_store = 1'b0; mode = 3'd0; data_idx = d; opnd_a = 16'hDEAD;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk("R12 done seen", {15'd0, done}, 16'd1);
        got_op  = operand;
        got_cnt = acc_count;
        got_ill = illegal;
        @(negedge clk);
        chk("R12 done one cycle", {15'd0, done}, 16'd0);
    endtask

    task automatic t_reset();
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 req", {15'd0, mem_req}, 16'd0);
        chk("R1 illegal", {15'd0, illegal}, 16'd0);
        issue(1'b0, 3'd1, 3'd0, 3'd7, 16'h0, 16'h0, 0, 1'b0);
        chk("R1 reg7 after reset", got_op, 16'h0000);
    endtask

    task automatic t_imm();
        issue(1'b0, 3'd0, 3'd1, 3'd0, 16'h0030, 16'h0, 0, 1'b0);
        chk("R2 operand", got_op, 16'h0030);
        chk("R2 count", {14'd0, got_cnt}, 16'd0);
        chk("R2 no access", 16'(nlog), 16'd0);
        issue(1'b0, 3'd0, 3'd2, 3'd0, 16'h0005, 16'h0, 0, 1'b0);
        issue(1'b0, 3'd0, 3'd3, 3'd0, 16'hFFF0, 16'h0, 0, 1'b0);
        issue(1'b0, 3'd0, 3'd4, 3'd0, 16'h00A0, 16'h0, 0, 1'b0);
        issue(1'b0, 3'd0, 3'd5, 3'd0, 16'h0077, 16'h0, 0, 1'b0);
    endtask

    task automatic t_reg();
        issue(1'b0, 3'd1, 3'd7, 3'd3, 16'h9999, 16'h0, 0, 1'b0);
        chk("R3 operand", got_op, 16'hFFF0);
        chk("R3 count", {14'd0, got_cnt}, 16'd0);
        chk("R3 no access", 16'(nlog), 16'd0);
    endtask

    task automatic t_direct();
        mem[8'h12] = 16'h5A5A;
        issue(1'b0, 3'd2, 3'd6, 3'd0, 16'h0012, 16'h0, 2, 1'b0);
        chk("R4 operand", got_op, 16'h5A5A);
        chk("R4 accesses", 16'(nlog), 16'd1);
        chk("R4 addr", log_addr[0], 16'h0012);
        chk("R4 read", {15'd0, log_we[0]}, 16'd0);
        chk("R4 count", {14'd0, got_cnt}, 16'd1);
        issue(1'b0, 3'd1, 3'd7, 3'd6, 16'h0, 16'h0, 0, 1'b0);
        chk("R13 loaded reg visible", got_op, 16'h5A5A);
    endtask

    task automatic t_rind();
        mem[8'h30] = 16'h1111;
        issue(1'b0, 3'd3, 3'd6, 3'd1, 16'h0999, 16'h0, 1, 1'b0);
        chk("R5 addr", log_addr[0], 16'h0030);
        chk("R5 operand", got_op, 16'h1111);
        chk("R5 count", {14'd0, got_cnt}, 16'd1);
    endtask

    task automatic t_mind();
        mem[8'h40] = 16'h0055;
        mem[8'h55] = 16'h2222;
        issue(1'b0, 3'd4, 3'd6, 3'd0, 16'h0040, 16'h0, 2, 1'b0);
        chk("R6 accesses", 16'(nlog), 16'd2);
        chk("R6 first addr", log_addr[0], 16'h0040);
        chk("R6 second addr", log_addr[1], 16'h0055);
        chk("R6 operand", got_op, 16'h2222);
        chk("R6 count", {14'd0, got_cnt}, 16'd2);
    endtask

    task automatic t_idx_pc();
        mem[8'h10] = 16'h3333;
        issue(1'b0, 3'd5, 3'd6, 3'd3, 16'h0020, 16'h0, 0, 1'b0);
        chk("R7 wrapped addr", log_addr[0], 16'h0010);
        chk("R7 operand", got_op, 16'h3333);
        chk("R7 count", {14'd0, got_cnt}, 16'd1);
        mem[8'h02] = 16'h4444;
        issue(1'b0, 3'd6, 3'd6, 3'd1, 16'h0004, 16'hFFFE, 1, 1'b0);
        chk("R8 wrapped addr", log_addr[0], 16'h0002);
        chk("R8 operand", got_op, 16'h4444);
        chk("R8 count", {14'd0, got_cnt}, 16'd1);
    endtask

    task automatic t_store();
        issue(1'b1, 3'd2, 3'd4, 3'd0, 16'h0060, 16'h0, 1, 1'b0);
        chk("R9 direct write", {15'd0, log_we[0]}, 16'd1);
        chk("R9 direct addr", log_addr[0], 16'h0060);
        chk("R9 direct data", log_wd[0], 16'h00A0);
        chk("R9 direct count", {14'd0, got_cnt}, 16'd1);
        issue(1'b1, 3'd4, 3'd5, 3'd0, 16'h0040, 16'h0, 3, 1'b0);
        chk("R9 mind accesses", 16'(nlog), 16'd2);
        chk("R9 mind first read", {15'd0, log_we[0]}, 16'd0);
        chk("R9 mind first addr", log_addr[0], 16'h0040);
        chk("R9 mind write", {15'd0, log_we[1]}, 16'd1);
        chk("R9 mind addr", log_addr[1], 16'h0055);
        chk("R9 mind data", log_wd[1], 16'h0077);
        issue(1'b1, 3'd5, 3'd4, 3'd2, 16'h0008, 16'h0, 0, 1'b0);
        chk("R9 idx addr", log_addr[0], 16'h000D);
        issue(1'b0, 3'd1, 3'd6, 3'd4, 16'h0, 16'h0, 0, 1'b0);
        chk("R9 source reg unchanged", got_op, 16'h00A0);
        issue(1'b0, 3'd2, 3'd0, 3'd0, 16'h0060, 16'h0, 0, 1'b0);
        chk("R9 stored value readable", got_op, 16'h00A0);
    endtask

    task automatic t_illegal();
        issue(1'b1, 3'd0, 3'd1, 3'd0, 16'h0BAD, 16'h0, 0, 1'b0);
        chk("R10 store imm flag", {15'd0, got_ill}, 16'd1);
        chk("R10 store imm count", {14'd0, got_cnt}, 16'd0);
        chk("R10 store imm no access", 16'(nlog), 16'd0);
        issue(1'b1, 3'd1, 3'd1, 3'd2, 16'h0, 16'h0, 0, 1'b0);
        chk("R10 store reg flag", {15'd0, got_ill}, 16'd1);
        chk("R10 store reg no access", 16'(nlog), 16'd0);
        issue(1'b0, 3'd7, 3'd1, 3'd0, 16'h0012, 16'h0, 0, 1'b0);
        chk("R10 mode7 flag", {15'd0, got_ill}, 16'd1);
        chk("R10 mode7 no access", 16'(nlog), 16'd0);
        issue(1'b0, 3'd1, 3'd6, 3'd1, 16'h0, 16'h0, 0, 1'b0);
        chk("R10 reg untouched", got_op, 16'h0030);
        chk("R10 legal flag clear", {15'd0, got_ill}, 16'd0);
    endtask

    task automatic t_busy();
        issue(1'b0, 3'd2, 3'd6, 3'd0, 16'h0012, 16'h0, 3, 1'b1);
        chk("R12 stray start one access", 16'(nlog), 16'd1);
        chk("R11 operand after wait", got_op, 16'h5A5A);
        repeat (4) @(negedge clk);
        chk("R12 no second run", {15'd0, busy}, 16'd0);
        issue(1'b0, 3'd1, 3'd7, 3'd6, 16'h0, 16'h0, 0, 1'b0);
        chk("R12 reg not overwritten", got_op, 16'h5A5A);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 16'h0100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm();
        t_reg();
        t_direct();
        t_rind();
        t_mind();
        t_idx_pc();
        t_store();
        t_illegal();
        t_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(4 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule